// File: doc/BRIEF.md
# Configurable UART Frame Transceiver

This block serialises parallel words onto an asynchronous serial line and recovers words from an incoming line. One oversampling tick drives both directions. A control bit chooses how many ticks each bit lasts: sixteen by default, or eight. The frame format comes from static control inputs: a two-bit word-length code, a parity enable with an odd/even select, and a two-bit stop code. The transmitter takes words through a valid/ready handshake. The receiver reports each recovered word as a one-cycle pulse, together with a parity-error flag and a framing-error flag.

The block sits between a baud-tick generator and a register file, and both of those live elsewhere. The format is captured when a frame starts, so a change to the controls in the middle of a frame only affects the next frame. Each direction runs only while the global enable and its own direction enable are both high.

Top module: `uart_xcvr`

## Requirements
- R1: The word-length code sets the total word size including any parity bit: 2'b00 gives 8 bits, 2'b01 gives 9 and 2'b10 gives 7. Code 2'b11 raises cfg_err, holds tx_ready low and starts no frame.
- R2: When parity is enabled, the parity bit is one of the word bits, so the data field has one bit fewer than the word size. The parity bit makes the count of ones in data plus parity even when par_odd=0, and odd when par_odd=1. When parity is disabled, no parity bit is sent.
- R3: Stop code 2'b00 gives one stop bit and 2'b10 gives two. Codes 2'b01 and 2'b11 raise cfg_err and hold tx_ready low.
- R4: The line idles high. A transmitted frame is one low start bit, then the data bits least significant first, then the parity bit if enabled, then the stop bits, which are high. Every bit lasts 16 ticks, or 8 ticks when ovs8=1.
- R5: tx_ready is high only while the transmitter is idle, enabled and correctly configured. A word is taken on a clock where tx_valid and tx_ready are both high.
- R6: The transmitter runs only while blk_en and tx_en are both 1. The receiver runs only while blk_en and rx_en are both 1. While the receiver is off, traffic on rxd produces no rx_valid.
- R7: The receiver samples each bit at the middle of its window. A start bit that is no longer low at its midpoint is dropped as a false start and produces no word.
- R8: Each received frame gives exactly one single-cycle rx_valid pulse. rx_data holds the data bits, least significant first, with zeros above the data field.
- R9: rx_par_err is high with rx_valid when parity is enabled and the received parity bit does not match the data under the selected parity sense.
- R10: rx_frm_err is high with rx_valid when any stop bit samples low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| samp_tick | input | 1 | Oversampling tick, one clock wide |
| blk_en | input | 1 | Global enable |
| tx_en | input | 1 | Transmit direction enable |
| rx_en | input | 1 | Receive direction enable |
| word_code | input | 2 | Word-length code |
| par_en | input | 1 | Parity enable |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| stop_code | input | 2 | Stop-bit code |
| ovs8 | input | 1 | 1 selects 8 ticks per bit, 0 selects 16 |
| tx_data | input | 9 | Word to transmit |
| tx_valid | input | 1 | tx_data is valid |
| tx_ready | output | 1 | Transmitter can accept a word |
| txd | output | 1 | Serial output line |
| rxd | input | 1 | Serial input line |
| rx_data | output | 9 | Received data, zero-extended |
| rx_valid | output | 1 | One-cycle pulse when a word arrives |
| rx_par_err | output | 1 | Parity mismatch, qualified by rx_valid |
| rx_frm_err | output | 1 | Stop bit sampled low, qualified by rx_valid |
| cfg_err | output | 1 | Unsupported word or stop code |

## Verification
Eight format vectors are sent with the transmitter looped back into the receiver. They cover all three word sizes, no parity, even and odd parity, one and two stop bits, and both oversampling rates.

Each transmitted frame is also sampled bit by bit against a frame built in the bench. This catches faults that a loopback alone would hide, such as a reversed parity sense or swapped bit order that the receiver would undo.

Frames driven by hand check the error paths:
- a flipped parity bit,
- a low first stop bit,
- a low second stop bit,
- a short glitch that must be dropped as a false start,
- traffic while the receiver is disabled.

// File: rtl/uart_xcvr_pkg.sv
// Shared types and helpers for the UART frame transceiver.
// Assumes data words never exceed UART_DW bits.
package uart_xcvr_pkg;
    localparam int UART_DW = 9;
    localparam int NBIT_W  = 4;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PAR,
        PH_STOP
    } phase_e;

    typedef struct packed {
        logic [NBIT_W-1:0] n_data;   // data bits, excluding parity
        logic              par_en;
        logic              par_odd;
        logic              two_stop;
        logic              ovs8;
    } frame_cfg_t;

    // Mask keeping the low n bits of a word.
    function automatic logic [UART_DW-1:0] low_mask(logic [NBIT_W-1:0] n);
        logic [UART_DW-1:0] m;
        for (int i = 0; i < UART_DW; i++) begin
            m[i] = (i < int'(n));
        end
        return m;
    endfunction
endpackage

// File: rtl/uart_fmt_decode.sv
// Turns the raw format controls into a frame descriptor and flags
// unsupported codes. Purely combinational; assumes the controls are static
// for the duration of a frame (the paths latch the descriptor anyway).
module uart_fmt_decode
    import uart_xcvr_pkg::*;
(
    input  logic [1:0]  word_code,
    input  logic        par_en,
    input  logic        par_odd,
    input  logic [1:0]  stop_code,
    input  logic        ovs8,
    output frame_cfg_t  fmt,
    output logic        cfg_err
);
    logic [NBIT_W-1:0] word_bits;

    // Word size from the split two-bit code.
    always_comb begin
        case (word_code)
            2'b01:   word_bits = NBIT_W'(9);
            2'b10:   word_bits = NBIT_W'(7);
            default: word_bits = NBIT_W'(8);
        endcase
    end

    // Build the descriptor: parity steals one word bit.
    always_comb begin
        fmt.n_data   = word_bits - NBIT_W'(par_en);
        fmt.par_en   = par_en;
        fmt.par_odd  = par_odd;
        fmt.two_stop = stop_code[1];
        fmt.ovs8     = ovs8;
        cfg_err      = (word_code == 2'b11) || stop_code[0];
    end
endmodule

// File: rtl/uart_tx_path.sv
// Frame serialiser. Accepts a word by valid/ready, then shifts out
// start, data (LSB first), optional parity and stop bits, each lasting
// OVS_HI or OVS_LO ticks. Assumes samp_tick is a one-clock pulse.
module uart_tx_path
    import uart_xcvr_pkg::*;
#(
    parameter int OVS_HI = 16,
    parameter int OVS_LO = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               run,
    input  logic               cfg_ok,
    input  frame_cfg_t         fmt,
    input  logic [UART_DW-1:0] tx_data,
    input  logic               tx_valid,
    output logic               tx_ready,
    output logic               txd
);
    localparam int CNT_W = $clog2(OVS_HI);

    phase_e             ph;
    frame_cfg_t         fmt_q;
    logic [CNT_W-1:0]   cnt;
    logic [NBIT_W-1:0]  bidx;
    logic [UART_DW-1:0] sh;
    logic               pbit;
    logic               stop_left;
    logic               txd_q;
    logic [CNT_W-1:0]   bit_last;
    logic [UART_DW-1:0] masked;

    assign tx_ready = run && cfg_ok && (ph == PH_IDLE);
    assign txd      = txd_q;
    assign bit_last = fmt_q.ovs8 ? CNT_W'(OVS_LO - 1) : CNT_W'(OVS_HI - 1);
    assign masked   = tx_data & low_mask(fmt.n_data);

    // Frame sequencer: one bit period per OVS ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph        <= PH_IDLE;
            fmt_q     <= '0;
            cnt       <= '0;
            bidx      <= '0;
            sh        <= '0;
            pbit      <= 1'b0;
            stop_left <= 1'b0;
            txd_q     <= 1'b1;
        end else if (!run) begin
            ph    <= PH_IDLE;
            txd_q <= 1'b1;
        end else if (ph == PH_IDLE) begin
            txd_q <= 1'b1;
            if (tx_valid && tx_ready) begin
                fmt_q <= fmt;
                sh    <= masked;
                pbit  <= (^masked) ^ fmt.par_odd;
                cnt   <= '0;
                ph    <= PH_START;
                txd_q <= 1'b0;
            end
        end else if (tick) begin
            if (cnt != bit_last) begin
                cnt <= cnt + 1'b1;
            end else begin
                cnt <= '0;
                if (ph == PH_START) begin
                    ph    <= PH_DATA;
                    bidx  <= '0;
                    txd_q <= sh[0];
                end else if (ph == PH_DATA) begin
                    if (bidx == fmt_q.n_data - 1'b1) begin
                        if (fmt_q.par_en) begin
                            ph    <= PH_PAR;
                            txd_q <= pbit;
                        end else begin
                            ph        <= PH_STOP;
                            stop_left <= fmt_q.two_stop;
                            txd_q     <= 1'b1;
                        end
                    end else begin
                        bidx  <= bidx + 1'b1;
                        txd_q <= sh[bidx + 1'b1];
                    end
                end else if (ph == PH_PAR) begin
                    ph        <= PH_STOP;
                    stop_left <= fmt_q.two_stop;
                    txd_q     <= 1'b1;
                end else begin
                    if (stop_left) begin
                        stop_left <= 1'b0;
                    end else begin
                        ph <= PH_IDLE;
                    end
                end
            end
        end
    end

    // Line must be idle (high) whenever a new word may be taken.
    p_ready_line_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> txd);
    // A bad configuration never offers the handshake.
    p_cfgerr_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ok |-> !tx_ready);
    // Disabled transmitter drives idle on the following cycle.
    p_off_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> txd);
endmodule

// File: rtl/uart_rx_path.sv
// Frame recoverer. Synchronises rxd, detects a start edge on a tick,
// confirms it at mid-bit, then samples each later bit at its middle.
// Emits one rx_valid pulse per frame with parity/framing flags.
module uart_rx_path
    import uart_xcvr_pkg::*;
#(
    parameter int OVS_HI = 16,
    parameter int OVS_LO = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               run,
    input  logic               cfg_ok,
    input  frame_cfg_t         fmt,
    input  logic               rxd,
    output logic [UART_DW-1:0] rx_data,
    output logic               rx_valid,
    output logic               rx_par_err,
    output logic               rx_frm_err
);
    localparam int CNT_W = $clog2(OVS_HI);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   rxd_s;
    phase_e                 ph;
    frame_cfg_t             fmt_q;
    logic [CNT_W-1:0]       cnt;
    logic [NBIT_W-1:0]      bidx;
    logic [UART_DW-1:0]     sh;
    logic                   pbit;
    logic                   ferr;
    logic                   stop_left;
    logic [CNT_W-1:0]       bit_last;
    logic [CNT_W-1:0]       half;

    assign rxd_s    = sync_q[SYNC_STAGES-1];
    assign bit_last = fmt_q.ovs8 ? CNT_W'(OVS_LO - 1) : CNT_W'(OVS_HI - 1);
    assign half     = fmt_q.ovs8 ? CNT_W'(OVS_LO/2 - 1) : CNT_W'(OVS_HI/2 - 1);

    // Bring the asynchronous line into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
    end

    // Receive sequencer and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph         <= PH_IDLE;
            fmt_q      <= '0;
            cnt        <= '0;
            bidx       <= '0;
            sh         <= '0;
            pbit       <= 1'b0;
            ferr       <= 1'b0;
            stop_left  <= 1'b0;
            rx_data    <= '0;
            rx_valid   <= 1'b0;
            rx_par_err <= 1'b0;
            rx_frm_err <= 1'b0;
        end else begin
            rx_valid   <= 1'b0;
            rx_par_err <= 1'b0;
            rx_frm_err <= 1'b0;
            if (!run) begin
                ph <= PH_IDLE;
            end else if (tick) begin
                if (ph == PH_IDLE) begin
                    if (cfg_ok && !rxd_s) begin
                        fmt_q <= fmt;
                        ph    <= PH_START;
                        cnt   <= '0;
                        sh    <= '0;
                        ferr  <= 1'b0;
                    end
                end else if (ph == PH_START) begin
                    if (cnt == half) begin
                        if (rxd_s) begin
                            ph <= PH_IDLE;
                        end else begin
                            ph   <= PH_DATA;
                            cnt  <= '0;
                            bidx <= '0;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end else if (cnt != bit_last) begin
                    cnt <= cnt + 1'b1;
                end else begin
                    cnt <= '0;
                    if (ph == PH_DATA) begin
                        sh[bidx] <= rxd_s;
                        if (bidx == fmt_q.n_data - 1'b1) begin
                            if (fmt_q.par_en) begin
                                ph <= PH_PAR;
                            end else begin
                                ph        <= PH_STOP;
                                stop_left <= fmt_q.two_stop;
                            end
                        end else begin
                            bidx <= bidx + 1'b1;
                        end
                    end else if (ph == PH_PAR) begin
                        pbit      <= rxd_s;
                        ph        <= PH_STOP;
                        stop_left <= fmt_q.two_stop;
                    end else if (stop_left) begin
                        stop_left <= 1'b0;
                        ferr      <= ferr | !rxd_s;
                    end else begin
                        rx_valid   <= 1'b1;
                        rx_data    <= sh;
                        rx_par_err <= fmt_q.par_en && ((^sh) ^ pbit ^ fmt_q.par_odd);
                        rx_frm_err <= ferr | !rxd_s;
                        ph         <= PH_IDLE;
                    end
                end
            end
        end
    end

    // Each word is reported by a single-cycle pulse.
    p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
    // Error flags only appear alongside a delivered word.
    p_err_qualified_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_par_err || rx_frm_err) |-> rx_valid);
    // A disabled receiver delivers nothing.
    p_off_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !rx_valid);
endmodule

// File: rtl/uart_xcvr.sv
// Top of the UART frame transceiver: format decode plus independent
// transmit and receive paths sharing one oversampling tick.
// Assumes the tick generator and register file live outside.
module uart_xcvr
    import uart_xcvr_pkg::*;
#(
    parameter int OVS_HI = 16,
    parameter int OVS_LO = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               samp_tick,
    input  logic               blk_en,
    input  logic               tx_en,
    input  logic               rx_en,
    input  logic [1:0]         word_code,
    input  logic               par_en,
    input  logic               par_odd,
    input  logic [1:0]         stop_code,
    input  logic               ovs8,
    input  logic [UART_DW-1:0] tx_data,
    input  logic               tx_valid,
    output logic               tx_ready,
    output logic               txd,
    input  logic               rxd,
    output logic [UART_DW-1:0] rx_data,
    output logic               rx_valid,
    output logic               rx_par_err,
    output logic               rx_frm_err,
    output logic               cfg_err
);
    frame_cfg_t fmt;
    logic       tx_run;
    logic       rx_run;

    assign tx_run = blk_en && tx_en;
    assign rx_run = blk_en && rx_en;

    uart_fmt_decode u_fmt (
        .word_code (word_code),
        .par_en    (par_en),
        .par_odd   (par_odd),
        .stop_code (stop_code),
        .ovs8      (ovs8),
        .fmt       (fmt),
        .cfg_err   (cfg_err)
    );

    uart_tx_path #(.OVS_HI(OVS_HI), .OVS_LO(OVS_LO)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (samp_tick),
        .run      (tx_run),
        .cfg_ok   (!cfg_err),
        .fmt      (fmt),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .txd      (txd)
    );

    uart_rx_path #(.OVS_HI(OVS_HI), .OVS_LO(OVS_LO), .SYNC_STAGES(2)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (samp_tick),
        .run        (rx_run),
        .cfg_ok     (!cfg_err),
        .fmt        (fmt),
        .rxd        (rxd),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid),
        .rx_par_err (rx_par_err),
        .rx_frm_err (rx_frm_err)
    );

    // Unsupported stop codes are reported as a configuration error.
    p_stop_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stop_code[0] |-> (cfg_err && !tx_ready));
endmodule

// File: tb/uart_xcvr_bench.sv
module uart_xcvr_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       blk_en = 1'b0, tx_en = 1'b0, rx_en = 1'b0;
    logic [1:0] word_code = 2'b00, stop_code = 2'b00;
    logic       par_en = 1'b0, par_odd = 1'b0, ovs8 = 1'b0;
    logic [8:0] tx_data = '0;
    logic       tx_valid = 1'b0;
    logic       loop = 1'b1;
    logic       drv_rxd = 1'b1;
    logic       rxd;
    logic       tx_ready, txd, rx_valid, rx_par_err, rx_frm_err, cfg_err;
    logic [8:0] rx_data;
    int         checks = 0;
    int         fails = 0;

    assign rxd = loop ? txd : drv_rxd;

    uart_xcvr u_uart_xcvr (
        .clk(clk), .rst_n(rst_n), .samp_tick(tick), .blk_en(blk_en),
        .tx_en(tx_en), .rx_en(rx_en), .word_code(word_code), .par_en(par_en),
        .par_odd(par_odd), .stop_code(stop_code), .ovs8(ovs8),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .txd(txd), .rxd(rxd), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .cfg_err(cfg_err)
    );

    initial forever #2 clk = ~clk;
    initial forever begin
        @(negedge clk);
        tick = ~tick;
    end

    // Vector: [15:14] word code, [13] parity en, [12] odd, [11:10] stop code,
    // [9] ovs8, [8:0] data.
    localparam int NV = 8;
    localparam logic [15:0] VEC [NV] = '{
        {2'b00, 1'b0, 1'b0, 2'b00, 1'b0, 9'h0A5},
        {2'b01, 1'b0, 1'b0, 2'b00, 1'b0, 9'h1C3},
        {2'b10, 1'b0, 1'b0, 2'b10, 1'b0, 9'h05A},
        {2'b00, 1'b1, 1'b0, 2'b00, 1'b0, 9'h0B7},
        {2'b00, 1'b1, 1'b1, 2'b10, 1'b1, 9'h0B7},
        {2'b01, 1'b1, 1'b1, 2'b00, 1'b0, 9'h1FF},
        {2'b10, 1'b1, 1'b0, 2'b00, 1'b1, 9'h07F},
        {2'b01, 1'b1, 1'b0, 2'b10, 1'b1, 9'h100}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int n_data_of(input logic [1:0] wc, input logic pe);
        int t;
        t = (wc == 2'b01) ? 9 : (wc == 2'b10) ? 7 : 8;
        return t - int'(pe);
    endfunction

    function automatic logic [8:0] mask_of(input int n);
        logic [8:0] m;
        for (int i = 0; i < 9; i++) m[i] = (i < n);
        return m;
    endfunction

    // Build a line frame; flip_par corrupts parity, bad_stop (1 or 2) drops a stop bit.
    task automatic build_frame(input logic [1:0] wc, input logic pe, input logic po,
                               input logic two, input logic [8:0] d,
                               input bit flip_par, input int bad_stop,
                               output logic [15:0] bits, output int nb);
        int nd;
        nd = n_data_of(wc, pe);
        bits = '1;
        bits[0] = 1'b0;
        nb = 1;
        for (int i = 0; i < nd; i++) begin
            bits[nb] = d[i];
            nb++;
        end
        if (pe) begin
            bits[nb] = (^(d & mask_of(nd))) ^ po ^ flip_par;
            nb++;
        end
        bits[nb] = (bad_stop != 1);
        nb++;
        if (two) begin
            bits[nb] = (bad_stop != 2);
            nb++;
        end
    endtask

    task automatic send(input logic [8:0] d);
        int g;
        g = 0;
        @(negedge clk);
        while (!tx_ready && g < 2000) begin
            @(negedge clk);
            g++;
        end
        tx_data  = d;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic capture_tx(input int nb, input int bitclk, output logic [15:0] got);
        int g;
        g = 0;
        got = '1;
        @(negedge clk);
        while (txd && g < 2000) begin
            @(negedge clk);
            g++;
        end
        repeat (bitclk/2 - 1) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            got[i] = txd;
            repeat (bitclk) @(negedge clk);
        end
    endtask

    task automatic wait_rx(input int maxc, output bit seen, output logic [8:0] d,
                           output logic pe, output logic fe);
        seen = 0; d = '0; pe = 0; fe = 0;
        for (int i = 0; i < maxc && !seen; i++) begin
            @(negedge clk);
            if (rx_valid) begin
                seen = 1; d = rx_data; pe = rx_par_err; fe = rx_frm_err;
            end
        end
    endtask

    task automatic drive_frame(input logic [15:0] bits, input int nb, input int bitclk);
        for (int i = 0; i < nb; i++) begin
            drv_rxd = bits[i];
            repeat (bitclk) @(negedge clk);
        end
        drv_rxd = 1'b1;
    endtask

    task automatic set_fmt(input logic [15:0] v);
        word_code = v[15:14];
        par_en    = v[13];
        par_odd   = v[12];
        stop_code = v[11:10];
        ovs8      = v[9];
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] exp_bits, got_bits;
        int          nb, nd, bitclk, quiet;
        bit          seen;
        logic [8:0]  rd;
        logic        rpe, rfe;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state with everything disabled (R5, R6).
        chk(txd == 1'b1, "R4", "idle line after reset", txd, 1);
        chk(tx_ready == 1'b0, "R6", "ready while disabled", tx_ready, 0);
        chk(rx_valid == 1'b0, "R8", "rx_valid after reset", rx_valid, 0);
        chk(cfg_err == 1'b0, "R1", "cfg_err with default codes", cfg_err, 0);
        blk_en = 1; tx_en = 1; rx_en = 1;
        @(negedge clk);
        chk(tx_ready == 1'b1, "R5", "ready when idle and enabled", tx_ready, 1);

        // Loopback vector walk (R1, R2, R3, R4, R8).
        for (int v = 0; v < NV; v++) begin
            set_fmt(VEC[v]);
            loop = 1;
            build_frame(VEC[v][15:14], VEC[v][13], VEC[v][12], VEC[v][11],
                        VEC[v][8:0], 0, 0, exp_bits, nb);
            nd = n_data_of(VEC[v][15:14], VEC[v][13]);
            bitclk = VEC[v][9] ? 16 : 32;
            fork
                send(VEC[v][8:0]);
                capture_tx(nb, bitclk, got_bits);
                wait_rx(20 * bitclk + 200, seen, rd, rpe, rfe);
            join
            chk(got_bits == exp_bits, "R4", $sformatf("line bits vec %0d", v),
                int'(got_bits), int'(exp_bits));
            chk(seen && rd == (VEC[v][8:0] & mask_of(nd)), "R8",
                $sformatf("rx data vec %0d", v), int'(rd), int'(VEC[v][8:0] & mask_of(nd)));
            chk(!rpe && !rfe, "R2", $sformatf("no errors vec %0d", v), {rpe, rfe}, 0);
        end

        // Unsupported word code 11 (R1).
        repeat (400) @(negedge clk);
        set_fmt({2'b11, 1'b0, 1'b0, 2'b00, 1'b0, 9'h0});
        tx_data = 9'h055; tx_valid = 1;
        @(negedge clk);
        chk(cfg_err == 1'b1, "R1", "cfg_err for word code 11", cfg_err, 1);
        chk(tx_ready == 1'b0, "R1", "ready for word code 11", tx_ready, 0);
        quiet = 0;
        repeat (200) begin
            @(negedge clk);
            if (!txd) quiet++;
        end
        tx_valid = 0;
        chk(quiet == 0, "R1", "no frame started on code 11", quiet, 0);

        // Fractional stop codes (R3).
        set_fmt({2'b00, 1'b0, 1'b0, 2'b01, 1'b0, 9'h0});
        @(negedge clk);
        chk(cfg_err && !tx_ready, "R3", "stop code 01 flagged", {cfg_err, tx_ready}, 2);
        set_fmt({2'b00, 1'b0, 1'b0, 2'b11, 1'b0, 9'h0});
        @(negedge clk);
        chk(cfg_err && !tx_ready, "R3", "stop code 11 flagged", {cfg_err, tx_ready}, 2);

        // Transmit direction disabled (R6).
        set_fmt({2'b00, 1'b0, 1'b0, 2'b00, 1'b0, 9'h0});
        tx_en = 0;
        @(negedge clk);
        chk(tx_ready == 1'b0, "R6", "ready with tx_en low", tx_ready, 0);
        tx_en = 1;

        // Manual frames on rxd.
        loop = 0;
        // Parity mismatch, 8-bit word with even parity (R9).
        set_fmt({2'b00, 1'b1, 1'b0, 2'b00, 1'b0, 9'h0});
        build_frame(2'b00, 1, 0, 0, 9'h03C, 1, 0, exp_bits, nb);
        fork
            drive_frame(exp_bits, nb, 32);
            wait_rx(16 * 32, seen, rd, rpe, rfe);
        join
        chk(seen && rpe && !rfe, "R9", "parity error flagged", {seen, rpe, rfe}, 6);
        chk(rd == 9'h03C, "R9", "data with parity error", rd, 9'h03C);

        // First stop bit low (R10).
        set_fmt({2'b00, 1'b0, 1'b0, 2'b00, 1'b0, 9'h0});
        build_frame(2'b00, 0, 0, 0, 9'h0E1, 0, 1, exp_bits, nb);
        fork
            drive_frame(exp_bits, nb, 32);
            wait_rx(16 * 32, seen, rd, rpe, rfe);
        join
        chk(seen && rfe && !rpe, "R10", "framing error on stop", {seen, rpe, rfe}, 5);
        repeat (100) @(negedge clk);

        // Second of two stop bits low, 8x rate (R10).
        set_fmt({2'b00, 1'b0, 1'b0, 2'b10, 1'b1, 9'h0});
        build_frame(2'b00, 0, 0, 1, 9'h01E, 0, 2, exp_bits, nb);
        fork
            drive_frame(exp_bits, nb, 16);
            wait_rx(16 * 16, seen, rd, rpe, rfe);
        join
        chk(seen && rfe, "R10", "framing error on second stop", {seen, rfe}, 3);
        repeat (100) @(negedge clk);

        // Short glitch rejected as false start (R7).
        set_fmt({2'b00, 1'b0, 1'b0, 2'b00, 1'b0, 9'h0});
        drv_rxd = 0;
        repeat (4) @(negedge clk);
        drv_rxd = 1;
        quiet = 0;
        repeat (600) begin
            @(negedge clk);
            if (rx_valid) quiet++;
        end
        chk(quiet == 0, "R7", "false start produces no word", quiet, 0);
        build_frame(2'b00, 0, 0, 0, 9'h069, 0, 0, exp_bits, nb);
        fork
            drive_frame(exp_bits, nb, 32);
            wait_rx(16 * 32, seen, rd, rpe, rfe);
        join
        chk(seen && rd == 9'h069, "R7", "good frame after glitch", rd, 9'h069);
        repeat (100) @(negedge clk);

        // Receiver disabled ignores the line (R6).
        rx_en = 0;
        quiet = 0;
        fork
            drive_frame(exp_bits, nb, 32);
            begin
                repeat (12 * 32) begin
                    @(negedge clk);
                    if (rx_valid) quiet++;
                end
            end
        join
        chk(quiet == 0, "R6", "no word with rx_en low", quiet, 0);
        rx_en = 1; blk_en = 0;
        quiet = 0;
        fork
            drive_frame(exp_bits, nb, 32);
            begin
                repeat (12 * 32) begin
                    @(negedge clk);
                    if (rx_valid) quiet++;
                end
            end
        join
        chk(quiet == 0, "R6", "no word with blk_en low", quiet, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule